// File: doc/BRIEF.md
# Almost-Empty / Almost-Full Offset Setup Sequencer

This block prepares the threshold offsets for a pair of FIFOs, one carrying data from port A to port B (the A-to-B FIFO) and one carrying data back (the B-to-A FIFO). Each FIFO has an almost-empty offset and an almost-full offset, each 9 bits wide. The downstream flag logic compares these offsets with FIFO fill levels. The block does not hold the FIFO storage and does not compute the flags.

Each FIFO has its own synchronous active-high reset. At the last clock edge of a reset, a 2-bit select input picks the setup method. A non-zero select loads a fixed preset into that FIFO's two offsets. If both resets are held together with the select at zero, the block enters serial setup instead. In serial setup, the next four accepted port-A writes are diverted into the offset registers and are not stored in the A-to-B FIFO. Port B stays not-ready for input until the fourth of these writes is taken. After that, both FIFOs run normally.

Top module: `flagcfg_seq`

## Requirements
- R1: At a clock edge where a FIFO's reset is high, select `2'b01` loads 8, `2'b10` loads 16 and `2'b11` loads 64 into both offsets of that FIFO. The new values are visible from the next cycle.
- R2: A reset of one FIFO leaves the other FIFO's offsets unchanged.
- R3: Serial setup starts only when the last reset edge has both resets high and the select at `2'b00`. A reset of a single FIFO with select `2'b00` loads 64 into both of its offsets and leaves normal operation enabled.
- R4: In serial setup, the first four accepted port-A writes load `a_data[8:0]` (bit 8 is the MSB) in this order: A-to-B almost-full, A-to-B almost-empty, B-to-A almost-full, B-to-A almost-empty. Each value is visible the cycle after its write. Cycles without a write do not advance the order.
- R5: Setup writes never assert `fifo_ab_we`.
- R6: A written offset of 0 is stored as 1, and a written offset above 508 is stored as 508. Values from 1 to 508 are stored unchanged.
- R7: During serial setup `a_ready` is high and `b_ready` is low. `b_ready` goes high in the cycle after the fourth setup write.
- R8: Once setup is complete, an accepted port-A write asserts `fifo_ab_we` in the same cycle and leaves all offsets unchanged.
- R9: `fifo_ba_we` is asserted only when `b_wr_en` is high and `b_ready` is high.
- R10: While a FIFO's reset is high, the ready output of its input port is low and its RAM write enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_ab | input | 1 | Synchronous active-high reset of the A-to-B FIFO |
| rst_ba | input | 1 | Synchronous active-high reset of the B-to-A FIFO |
| sel | input | 2 | Offset setup select, sampled while a reset is high |
| a_wr_en | input | 1 | Port-A write strobe |
| a_data | input | 36 | Port-A write data; bits 8..0 carry setup offsets |
| b_wr_en | input | 1 | Port-B write strobe |
| a_ready | output | 1 | Port A may write |
| b_ready | output | 1 | Port B may write |
| fifo_ab_we | output | 1 | RAM write enable of the A-to-B FIFO |
| fifo_ab_wdata | output | 36 | RAM write data of the A-to-B FIFO |
| fifo_ba_we | output | 1 | RAM write enable of the B-to-A FIFO |
| ae_ab_ofs | output | 9 | A-to-B almost-empty offset |
| af_ab_ofs | output | 9 | A-to-B almost-full offset |
| ae_ba_ofs | output | 9 | B-to-A almost-empty offset |
| af_ba_ofs | output | 9 | B-to-A almost-full offset |

## Verification
The ready outputs and RAM write enables are combinational. They respond in the same cycle as the strobe or reset, so the bench checks them shortly after it changes its inputs. Offsets are registered. They change at the edge that samples a reset or a setup write, so the bench checks them after that edge, in the following low clock phase. `b_ready` rises one edge after the fourth setup write. The bench checks it is still low after the third write and high immediately after the fourth.

// File: rtl/flagcfg_pkg.sv
package flagcfg_pkg;

    localparam int OFS_W     = 9;
    localparam int OFS_MIN   = 1;
    localparam int OFS_MAX   = 508;
    localparam int NUM_SLOTS = 4;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);

    localparam int PRESET_LOW  = 8;
    localparam int PRESET_MID  = 16;
    localparam int PRESET_HIGH = 64;

    typedef logic [OFS_W-1:0] ofs_t;

    typedef struct packed {
        ofs_t ae;
        ofs_t af;
    } ofs_pair_t;

    typedef enum logic [1:0] {
        SEL_SERIAL = 2'b00,
        SEL_LOW    = 2'b01,
        SEL_MID    = 2'b10,
        SEL_HIGH   = 2'b11
    } sel_e;

    // Setup write order; a slot index is 2*fifo + (1 for almost-empty)
    typedef enum logic [SLOT_W-1:0] {
        SLOT_AF_AB = 2'd0,
        SLOT_AE_AB = 2'd1,
        SLOT_AF_BA = 2'd2,
        SLOT_AE_BA = 2'd3
    } slot_e;

    function automatic ofs_t preset_val(sel_e s);
        case (s)
            SEL_LOW: return ofs_t'(PRESET_LOW);
            SEL_MID: return ofs_t'(PRESET_MID);
            default: return ofs_t'(PRESET_HIGH);
        endcase
    endfunction

    function automatic ofs_t clamp_ofs(ofs_t v);
        if (int'(v) < OFS_MIN) return ofs_t'(OFS_MIN);
        if (int'(v) > OFS_MAX) return ofs_t'(OFS_MAX);
        return v;
    endfunction

endpackage

// File: rtl/flagcfg_step.sv
module flagcfg_step
    import flagcfg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_ab,
    input  logic                 rst_ba,
    input  sel_e                 sel,
    input  logic                 wr_stb,
    output logic                 done,
    output logic [NUM_SLOTS-1:0] slot_we
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

    logic [SLOT_W-1:0] cnt;
    logic              any_rst;
    logic              prog_take;

    assign any_rst   = rst_ab | rst_ba;
    assign prog_take = !done && wr_stb && !any_rst;

    always_ff @(posedge clk) begin
        if (any_rst) begin
            done <= !(rst_ab && rst_ba && sel == SEL_SERIAL);
            cnt  <= '0;
        end else if (prog_take) begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST_SLOT) begin
                done <= 1'b1;
            end
        end
    end

    always_comb begin
        slot_we = '0;
        if (prog_take) begin
            slot_we[cnt] = 1'b1;
        end
    end

endmodule

// File: rtl/flagcfg_offreg.sv
module flagcfg_offreg
    import flagcfg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_fifo,
    input  sel_e      sel,
    input  logic      we_ae,
    input  logic      we_af,
    input  ofs_t      wr_val,
    output ofs_pair_t pair
);

    ofs_t lim_val;
    assign lim_val = clamp_ofs(wr_val);

    always_ff @(posedge clk) begin
        if (rst_fifo) begin
            pair.ae <= preset_val(sel);
            pair.af <= preset_val(sel);
        end else begin
            if (we_ae) pair.ae <= lim_val;
            if (we_af) pair.af <= lim_val;
        end
    end

endmodule

// File: rtl/flagcfg_seq.sv
module flagcfg_seq
    import flagcfg_pkg::*;
#(
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_ab,
    input  logic              rst_ba,
    input  logic [1:0]        sel,
    input  logic              a_wr_en,
    input  logic [DATA_W-1:0] a_data,
    input  logic              b_wr_en,
    output logic              a_ready,
    output logic              b_ready,
    output logic              fifo_ab_we,
    output logic [DATA_W-1:0] fifo_ab_wdata,
    output logic              fifo_ba_we,
    output logic [OFS_W-1:0]  ae_ab_ofs,
    output logic [OFS_W-1:0]  af_ab_ofs,
    output logic [OFS_W-1:0]  ae_ba_ofs,
    output logic [OFS_W-1:0]  af_ba_ofs
);

    localparam int NUM_FIFO = NUM_SLOTS / 2;

    sel_e                 sel_c;
    logic                 done;
    logic [NUM_SLOTS-1:0] slot_we;
    logic [NUM_FIFO-1:0]  rst_v;
    ofs_pair_t            pairs [NUM_FIFO];
    ofs_t                 wr_val;

    assign sel_c  = sel_e'(sel);
    assign rst_v  = {rst_ba, rst_ab};
    assign wr_val = a_data[OFS_W-1:0];

    assign a_ready = !rst_ab;

    flagcfg_step u_step (
        .clk     (clk),
        .rst_ab  (rst_ab),
        .rst_ba  (rst_ba),
        .sel     (sel_c),
        .wr_stb  (a_wr_en && a_ready),
        .done    (done),
        .slot_we (slot_we)
    );

    for (genvar g = 0; g < NUM_FIFO; g++) begin : g_fifo
        flagcfg_offreg u_reg (
            .clk      (clk),
            .rst_fifo (rst_v[g]),
            .sel      (sel_c),
            .we_ae    (slot_we[2*g+1]),
            .we_af    (slot_we[2*g]),
            .wr_val   (wr_val),
            .pair     (pairs[g])
        );
    end

    assign b_ready       = !rst_ba && done;
    assign fifo_ab_we    = a_wr_en && a_ready && done;
    assign fifo_ab_wdata = a_data;
    assign fifo_ba_we    = b_wr_en && b_ready;

    assign ae_ab_ofs = pairs[0].ae;
    assign af_ab_ofs = pairs[0].af;
    assign ae_ba_ofs = pairs[1].ae;
    assign af_ba_ofs = pairs[1].af;

endmodule

// File: rtl/flagcfg_chk.sv
module flagcfg_chk
    import flagcfg_pkg::*;
(
    input logic             clk,
    input logic             rst_ab,
    input logic             rst_ba,
    input logic [1:0]       sel,
    input logic             a_wr_en,
    input logic             b_wr_en,
    input logic             b_ready,
    input logic             fifo_ab_we,
    input logic             fifo_ba_we,
    input logic [OFS_W-1:0] ae_ab_ofs,
    input logic [OFS_W-1:0] af_ab_ofs,
    input logic [OFS_W-1:0] ae_ba_ofs,
    input logic [OFS_W-1:0] af_ba_ofs
);

    // R5
    setup_no_store_chk: assert property (@(posedge clk) disable iff (rst_ab || rst_ba)
        !b_ready |-> !fifo_ab_we);

    // R9
    b_gate_chk: assert property (@(posedge clk) disable iff (rst_ab || rst_ba)
        fifo_ba_we |-> (b_ready && b_wr_en));

    // R6
    ofs_range_chk: assert property (@(posedge clk) disable iff (rst_ab || rst_ba)
        (ae_ab_ofs >= OFS_W'(OFS_MIN)) && (ae_ab_ofs <= OFS_W'(OFS_MAX)) &&
        (af_ab_ofs >= OFS_W'(OFS_MIN)) && (af_ab_ofs <= OFS_W'(OFS_MAX)) &&
        (ae_ba_ofs >= OFS_W'(OFS_MIN)) && (ae_ba_ofs <= OFS_W'(OFS_MAX)) &&
        (af_ba_ofs >= OFS_W'(OFS_MIN)) && (af_ba_ofs <= OFS_W'(OFS_MAX)));

    // R1
    preset_mid_chk: assert property (@(posedge clk) disable iff (rst_ba)
        ($past(rst_ba) && $past(sel) == 2'b10) |-> (ae_ba_ofs == 9'd16 && af_ba_ofs == 9'd16));

    // R8
    ofs_hold_chk: assert property (@(posedge clk) disable iff (rst_ab || rst_ba)
        (b_ready && $past(b_ready) && !$past(rst_ab)) |->
        ($stable(ae_ab_ofs) && $stable(af_ab_ofs) && $stable(ae_ba_ofs) && $stable(af_ba_ofs)));

    // R7
    b_rise_chk: assert property (@(posedge clk) disable iff (rst_ab || rst_ba)
        ($rose(b_ready) && !$past(rst_ba)) |-> $past(a_wr_en));

endmodule

bind flagcfg_seq flagcfg_chk u_chk (
    .clk        (clk),
    .rst_ab     (rst_ab),
    .rst_ba     (rst_ba),
    .sel        (sel),
    .a_wr_en    (a_wr_en),
    .b_wr_en    (b_wr_en),
    .b_ready    (b_ready),
    .fifo_ab_we (fifo_ab_we),
    .fifo_ba_we (fifo_ba_we),
    .ae_ab_ofs  (ae_ab_ofs),
    .af_ab_ofs  (af_ab_ofs),
    .ae_ba_ofs  (ae_ba_ofs),
    .af_ba_ofs  (af_ba_ofs)
);

// File: tb/sim_flagcfg_seq.sv
`timescale 1ns/1ps
module sim_flagcfg_seq;

    logic        clk = 1'b0;
    logic        rst_ab = 1'b1;
    logic        rst_ba = 1'b1;
    logic [1:0]  sel = 2'b11;
    logic        a_wr_en = 1'b1;
    logic [35:0] a_data = '0;
    logic        b_wr_en = 1'b1;
    logic        a_ready, b_ready, fifo_ab_we, fifo_ba_we;
    logic [35:0] fifo_ab_wdata;
    logic [8:0]  ae_ab_ofs, af_ab_ofs, ae_ba_ofs, af_ba_ofs;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    flagcfg_seq u0 (
        .clk(clk), .rst_ab(rst_ab), .rst_ba(rst_ba), .sel(sel),
        .a_wr_en(a_wr_en), .a_data(a_data), .b_wr_en(b_wr_en),
        .a_ready(a_ready), .b_ready(b_ready),
        .fifo_ab_we(fifo_ab_we), .fifo_ab_wdata(fifo_ab_wdata), .fifo_ba_we(fifo_ba_we),
        .ae_ab_ofs(ae_ab_ofs), .af_ab_ofs(af_ab_ofs),
        .ae_ba_ofs(ae_ba_ofs), .af_ba_ofs(af_ba_ofs)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_ofs(string req, int ae_ab, int af_ab, int ae_ba, int af_ba);
        check({req, " ae_ab"}, int'(ae_ab_ofs), ae_ab);
        check({req, " af_ab"}, int'(af_ab_ofs), af_ab);
        check({req, " ae_ba"}, int'(ae_ba_ofs), ae_ba);
        check({req, " af_ba"}, int'(af_ba_ofs), af_ba);
    endtask

    task automatic apply_rst(logic r_ab, logic r_ba, logic [1:0] s);
        rst_ab = r_ab; rst_ba = r_ba; sel = s;
        cyc();
        rst_ab = 1'b0; rst_ba = 1'b0; sel = 2'b00;
        #1;
    endtask

    task automatic setup_write(int v, string req);
        a_wr_en = 1'b1;
        a_data  = {27'h5A5A5A5, 9'(v)};
        #1;
        check({req, " R5 setup write not stored"}, int'(fifo_ab_we), 0);
        cyc();
        a_wr_en = 1'b0;
        #1;
    endtask

    task automatic t_reset_state;
        cyc(); cyc();
        #1;
        check("R10 a_ready in reset", int'(a_ready), 0);
        check("R10 b_ready in reset", int'(b_ready), 0);
        check("R10 ab we in reset", int'(fifo_ab_we), 0);
        check("R10 ba we in reset", int'(fifo_ba_we), 0);
        a_wr_en = 1'b0; b_wr_en = 1'b0;
        rst_ab = 1'b0; rst_ba = 1'b0; sel = 2'b00;
        #1;
        check_ofs("R1 preset 64", 64, 64, 64, 64);
        check("R10 a_ready after reset", int'(a_ready), 1);
        check("R10 b_ready after reset", int'(b_ready), 1);
    endtask

    task automatic t_presets;
        apply_rst(1'b1, 1'b0, 2'b01);
        check_ofs("R1 R2 preset 8 on ab", 8, 8, 64, 64);
        apply_rst(1'b0, 1'b1, 2'b10);
        check_ofs("R1 R2 preset 16 on ba", 8, 8, 16, 16);
        apply_rst(1'b1, 1'b1, 2'b11);
        check_ofs("R1 preset 64 both", 64, 64, 64, 64);
    endtask

    task automatic t_lone_zero;
        apply_rst(1'b0, 1'b1, 2'b10);
        apply_rst(1'b1, 1'b0, 2'b00);
        check_ofs("R3 lone reset select zero", 64, 64, 16, 16);
        check("R3 b_ready after lone reset", int'(b_ready), 1);
        a_wr_en = 1'b1; a_data = 36'd7;
        #1;
        check("R3 lone reset stores data", int'(fifo_ab_we), 1);
        cyc();
        a_wr_en = 1'b0;
        #1;
        check_ofs("R3 write leaves offsets", 64, 64, 16, 16);
    endtask

    task automatic t_serial;
        apply_rst(1'b1, 1'b1, 2'b00);
        check("R7 a_ready in setup", int'(a_ready), 1);
        check("R7 b_ready in setup", int'(b_ready), 0);
        b_wr_en = 1'b1;
        #1;
        check("R9 ba we blocked in setup", int'(fifo_ba_we), 0);
        b_wr_en = 1'b0;
        setup_write(100, "R4");
        cyc();
        check("R4 idle cycle keeps order", int'(af_ab_ofs), 100);
        setup_write(200, "R4");
        setup_write(300, "R4");
        check("R7 b_ready after third write", int'(b_ready), 0);
        setup_write(400, "R4");
        check("R7 b_ready after fourth write", int'(b_ready), 1);
        check_ofs("R4 write order", 200, 100, 400, 300);
        b_wr_en = 1'b1;
        #1;
        check("R9 ba we after setup", int'(fifo_ba_we), 1);
        b_wr_en = 1'b0;
        a_wr_en = 1'b1; a_data = 36'h1_0000_0055;
        #1;
        check("R8 ab we after setup", int'(fifo_ab_we), 1);
        check("R8 write data passed", int'(fifo_ab_wdata == 36'h1_0000_0055), 1);
        cyc();
        a_wr_en = 1'b0;
        #1;
        check_ofs("R8 offsets held", 200, 100, 400, 300);
    endtask

    task automatic t_clamp;
        apply_rst(1'b1, 1'b1, 2'b00);
        setup_write(0, "R6");
        setup_write(509, "R6");
        setup_write(511, "R6");
        setup_write(508, "R6");
        check_ofs("R6 clamp", 508, 1, 508, 508);
        check("R6 b_ready", int'(b_ready), 1);
    endtask

    task automatic t_staggered;
        rst_ab = 1'b1; rst_ba = 1'b1; sel = 2'b00;
        cyc();
        rst_ab = 1'b0;
        cyc();
        rst_ba = 1'b0;
        #1;
        check("R3 staggered resets no setup", int'(b_ready), 1);
        check_ofs("R3 staggered offsets", 64, 64, 64, 64);
    endtask

    initial begin
        t_reset_state();
        t_presets();
        t_lone_zero();
        t_serial();
        t_clamp();
        t_staggered();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule